// File: doc/BRIEF.md
# Memory-Side Snoop Response Collector

This block sits on the memory side of a snooping coherence bus. For each read-shared or read-for-ownership request that a cache places on the bus, it records the request in a small table of pending transactions. It then gathers the per-cache snoop replies until every cache has reported. It ORs the shared and dirty indications together and chooses one of two paths. If no cache holds the line modified, the controller starts a memory read at once. If some cache holds it modified, the entry parks until that cache's flush has been written into memory, and only then is the line read and returned.

Memory is modelled inside the block as a line store with a fixed, configurable read latency. The table lets the controller keep taking new bus requests while older ones wait on a flush or on memory. Fills can therefore leave in an order different from the order the requests were accepted. Each fill carries the requester's ID, the line address and the line data, plus a flag that says whether the line may be held shared rather than exclusive. A table slot is released on the cycle its fill is presented. When no slot is free, or while a snoop collection is still open, the block raises a stall that holds the next bus request off.

Top module: `snoop_mem_ctrl`

## Requirements
- R1: During and after reset the table is empty, `req_stall` and `fill_valid` are 0, and memory line a holds (a*37+11) mod 2^DATA_W.
- R2: A request is accepted at a rising edge where `req_valid`=1 and `req_stall`=0. It takes the lowest-numbered free slot. From the next cycle `req_stall` stays 1 until that request's snoop collection completes, so only one collection is open at a time.
- R3: Snoop replies are sampled from the cycle after acceptance onward. Cache i reports by raising `snp_valid[i]`, and its `snp_shared[i]`/`snp_dirty[i]` count only in cycles where `snp_valid[i]`=1. The request resolves at the edge where every cache has reported at least once.
- R4: A request with no dirty report becomes ready at its resolving edge. Its memory read issues at the following edge, and `fill_valid` is 1 for exactly one cycle, starting MEM_LAT cycles after the resolving edge.
- R5: A request with a dirty report produces no fill until a writeback (`wb_valid`=1) to the same address is seen, either at or after its resolving edge. The release edge then takes the place of the resolving edge in the timing of R4.
- R6: A writeback stores `wb_data` into line `wb_addr` at its edge. A fill presented in the same cycle as a writeback to its line still carries the older content.
- R7: A fill carries the request's ID and address and the line content during the fill cycle. `fill_shared` is 1 only when the request was read-shared (`req_excl`=0) and some cache reported shared or dirty.
- R8: At most one memory read issues per cycle, taken from the lowest-numbered ready slot. Fills may leave out of acceptance order.
- R9: With all N_ENT slots occupied, `req_stall` is 1 and a request presented then is ignored, producing no fill. A slot is freed at the edge that ends its fill cycle.
- R10: One writeback releases every waiting entry whose address matches it, and their fills follow in slot order on successive cycles.
- R11: New requests keep being accepted and served while older entries wait on a writeback or on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_excl | input | 1 | 1 = read for ownership, 0 = read shared |
| req_id | input | ID_W | Requesting cache ID |
| req_addr | input | ADDR_W | Requested line address |
| req_stall | output | 1 | Request cannot be taken this cycle |
| snp_valid | input | N_CACHE | Per-cache snoop reply strobe |
| snp_shared | input | N_CACHE | Per-cache shared indication |
| snp_dirty | input | N_CACHE | Per-cache modified indication |
| wb_valid | input | 1 | Flush data from an owning cache |
| wb_addr | input | ADDR_W | Flushed line address |
| wb_data | input | DATA_W | Flushed line data |
| fill_valid | output | 1 | Fill presented this cycle |
| fill_id | output | ID_W | Requester ID of the fill |
| fill_addr | output | ADDR_W | Line address of the fill |
| fill_data | output | DATA_W | Line data |
| fill_shared | output | 1 | Line may be held shared |

## Verification
Clean read-shared and read-for-ownership requests with and without shared replies separate the timing of the clean path and the meaning of the shared flag. Staggered replies, with noise driven on the shared and dirty lines of caches that have not yet reported, show whether collection waits for every cache and masks replies that are not valid. Dirty requests overlapped with later clean ones, writebacks that land on the resolving edge or on a fill cycle, and two waiters released by one flush tell apart out-of-order completion, the release and forwarding rules, and slot-order issue. A full table with a request pushed against the stall, followed by mixed random traffic over a few addresses, exposes lost or duplicated fills.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [2:0] {
        ENT_FREE,
        ENT_SNOOP,
        ENT_WAIT_WB,
        ENT_READY,
        ENT_INFLIGHT
    } ent_state_e;

    typedef struct packed {
        logic shared;
        logic dirty;
    } snoop_sum_t;

    localparam int unsigned INIT_MUL = 37;
    localparam int unsigned INIT_ADD = 11;

    function automatic logic [31:0] init_word(input int unsigned line);
        return 32'(line * INIT_MUL + INIT_ADD);
    endfunction

endpackage

// File: rtl/smc_pick_first.sv
module smc_pick_first #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/smc_snoop_collect.sv
module smc_snoop_collect
    import smc_pkg::*;
#(
    parameter int N_CACHE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [N_CACHE-1:0] snp_valid,
    input  logic [N_CACHE-1:0] snp_shared,
    input  logic [N_CACHE-1:0] snp_dirty,
    output logic               busy,
    output logic               done,
    output snoop_sum_t         sum
);
    logic               busy_q;
    logic [N_CACHE-1:0] seen_q, shr_q, drt_q;
    logic [N_CACHE-1:0] seen_n, shr_n, drt_n;

    assign seen_n = seen_q | snp_valid;
    assign shr_n  = shr_q | (snp_valid & snp_shared);
    assign drt_n  = drt_q | (snp_valid & snp_dirty);

    assign busy       = busy_q;
    assign done       = busy_q && (&seen_n);
    assign sum.shared = |shr_n;
    assign sum.dirty  = |drt_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            seen_q <= '0;
            shr_q  <= '0;
            drt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            seen_q <= '0;
            shr_q  <= '0;
            drt_q  <= '0;
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
            end else begin
                seen_q <= seen_n;
                shr_q  <= shr_n;
                drt_q  <= drt_n;
            end
        end
    end
endmodule

// File: rtl/smc_line_store.sv
module smc_line_store
    import smc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem_q[a] <= DATA_W'(init_word(a));
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/smc_lat_pipe.sv
module smc_lat_pipe #(
    parameter int LAT = 6,
    parameter int SW  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [SW-1:0] in_slot,
    output logic          out_valid,
    output logic [SW-1:0] out_slot
);
    logic [LAT-1:0] v_q;
    logic [SW-1:0]  s_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
            for (int k = 0; k < LAT; k++) s_q[k] <= '0;
        end else begin
            v_q[0] <= in_valid;
            s_q[0] <= in_slot;
            for (int k = 1; k < LAT; k++) begin
                v_q[k] <= v_q[k-1];
                s_q[k] <= s_q[k-1];
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_slot  = s_q[LAT-1];
endmodule

// File: rtl/snoop_mem_ctrl.sv
module snoop_mem_ctrl
    import smc_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_ENT   = 4,
    parameter int ID_W    = 2,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    parameter int MEM_LAT = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_excl,
    input  logic [ID_W-1:0]    req_id,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_stall,
    input  logic [N_CACHE-1:0] snp_valid,
    input  logic [N_CACHE-1:0] snp_shared,
    input  logic [N_CACHE-1:0] snp_dirty,
    input  logic               wb_valid,
    input  logic [ADDR_W-1:0]  wb_addr,
    input  logic [DATA_W-1:0]  wb_data,
    output logic               fill_valid,
    output logic [ID_W-1:0]    fill_id,
    output logic [ADDR_W-1:0]  fill_addr,
    output logic [DATA_W-1:0]  fill_data,
    output logic               fill_shared
);
    localparam int SLOT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    // request table
    ent_state_e        st_q   [N_ENT];
    logic [ADDR_W-1:0] addr_q [N_ENT];
    logic [ID_W-1:0]   id_q   [N_ENT];
    logic [N_ENT-1:0]  excl_q;
    logic [N_ENT-1:0]  shr_q;

    logic [N_ENT-1:0] free_m, snoop_m, wait_m, ready_m, inflight_m, wb_hit;
    logic [N_ENT*ADDR_W-1:0] ent_addr_flat;

    for (genvar i = 0; i < N_ENT; i++) begin : g_mask
        assign free_m[i]     = (st_q[i] == ENT_FREE);
        assign snoop_m[i]    = (st_q[i] == ENT_SNOOP);
        assign wait_m[i]     = (st_q[i] == ENT_WAIT_WB);
        assign ready_m[i]    = (st_q[i] == ENT_READY);
        assign inflight_m[i] = (st_q[i] == ENT_INFLIGHT);
        assign wb_hit[i]     = wb_valid && (addr_q[i] == wb_addr);
        assign ent_addr_flat[i*ADDR_W +: ADDR_W] = addr_q[i];
    end

    // slot allocation and read issue
    logic              alloc_found, iss_found;
    logic [SLOT_W-1:0] alloc_idx, iss_idx;

    smc_pick_first #(.N(N_ENT), .IW(SLOT_W)) alloc_pick_i (
        .req(free_m), .found(alloc_found), .idx(alloc_idx)
    );
    smc_pick_first #(.N(N_ENT), .IW(SLOT_W)) issue_pick_i (
        .req(ready_m), .found(iss_found), .idx(iss_idx)
    );

    // snoop collection
    logic              col_busy, col_done, accept;
    snoop_sum_t        col_sum;
    logic [SLOT_W-1:0] cslot_q;

    assign req_stall = !alloc_found || col_busy;
    assign accept    = req_valid && !req_stall;

    smc_snoop_collect #(.N_CACHE(N_CACHE)) collect_i (
        .clk(clk), .rst(rst), .start(accept),
        .snp_valid(snp_valid), .snp_shared(snp_shared), .snp_dirty(snp_dirty),
        .busy(col_busy), .done(col_done), .sum(col_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) cslot_q <= '0;
        else if (accept) cslot_q <= alloc_idx;
    end

    // memory latency and line store
    logic              pipe_v;
    logic [SLOT_W-1:0] pipe_slot;
    logic [DATA_W-1:0] rd_data;

    smc_lat_pipe #(.LAT(MEM_LAT), .SW(SLOT_W)) pipe_i (
        .clk(clk), .rst(rst), .in_valid(iss_found), .in_slot(iss_idx),
        .out_valid(pipe_v), .out_slot(pipe_slot)
    );

    smc_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst(rst), .wr_en(wb_valid), .wr_addr(wb_addr),
        .wr_data(wb_data), .rd_addr(addr_q[pipe_slot]), .rd_data(rd_data)
    );

    assign fill_valid  = pipe_v;
    assign fill_id     = id_q[pipe_slot];
    assign fill_addr   = addr_q[pipe_slot];
    assign fill_data   = rd_data;
    assign fill_shared = shr_q[pipe_slot] && !excl_q[pipe_slot];

    // entry state transitions
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) begin
                st_q[i]   <= ENT_FREE;
                addr_q[i] <= '0;
                id_q[i]   <= '0;
            end
            excl_q <= '0;
            shr_q  <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                unique case (st_q[i])
                    ENT_FREE: begin
                        if (accept && alloc_idx == SLOT_W'(i)) begin
                            st_q[i]   <= ENT_SNOOP;
                            addr_q[i] <= req_addr;
                            id_q[i]   <= req_id;
                            excl_q[i] <= req_excl;
                            shr_q[i]  <= 1'b0;
                        end
                    end
                    ENT_SNOOP: begin
                        if (col_done && cslot_q == SLOT_W'(i)) begin
                            shr_q[i] <= col_sum.shared || col_sum.dirty;
                            st_q[i]  <= (col_sum.dirty && !wb_hit[i]) ? ENT_WAIT_WB : ENT_READY;
                        end
                    end
                    ENT_WAIT_WB: begin
                        if (wb_hit[i]) st_q[i] <= ENT_READY;
                    end
                    ENT_READY: begin
                        if (iss_found && iss_idx == SLOT_W'(i)) st_q[i] <= ENT_INFLIGHT;
                    end
                    ENT_INFLIGHT: begin
                        if (pipe_v && pipe_slot == SLOT_W'(i)) st_q[i] <= ENT_FREE;
                    end
                    default: st_q[i] <= ENT_FREE;
                endcase
            end
        end
    end
endmodule

// File: rtl/snoop_mem_ctrl_chk.sv
module snoop_mem_ctrl_chk #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 4,
    parameter int SLOT_W = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_stall,
    input logic                    wb_valid,
    input logic [ADDR_W-1:0]       wb_addr,
    input logic                    fill_valid,
    input logic [SLOT_W-1:0]       fill_slot,
    input logic [N_ENT-1:0]        free_m,
    input logic [N_ENT-1:0]        wait_m,
    input logic [N_ENT-1:0]        snoop_m,
    input logic [N_ENT-1:0]        inflight_m,
    input logic [N_ENT*ADDR_W-1:0] ent_addr_flat
);
    a_r9_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        (free_m == '0) |-> req_stall);

    a_r2_stall_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stall) |=> req_stall);

    a_r2_one_collection: assert property (@(posedge clk) disable iff (rst)
        $countones(snoop_m) <= 1);

    a_r5_fill_from_inflight: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> inflight_m[fill_slot]);

    a_r9_free_after_fill: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> free_m[$past(fill_slot)]);

    for (genvar i = 0; i < N_ENT; i++) begin : g_hold
        a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
            (wait_m[i] && !(wb_valid && ent_addr_flat[i*ADDR_W +: ADDR_W] == wb_addr))
            |=> wait_m[i]);
    end
endmodule

bind snoop_mem_ctrl snoop_mem_ctrl_chk #(
    .N_ENT(N_ENT), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_stall(req_stall),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .fill_valid(fill_valid),
    .fill_slot(pipe_slot), .free_m(free_m), .wait_m(wait_m),
    .snoop_m(snoop_m), .inflight_m(inflight_m), .ent_addr_flat(ent_addr_flat)
);

// File: tb/snoop_mem_ctrl_tb_top.sv
module snoop_mem_ctrl_tb_top;
    localparam int NC = 4, NE = 4, IDW = 2, AW = 4, DW = 16, LAT = 6;
    localparam int LINES = 1 << AW;
    localparam int S_FREE = 0, S_SNP = 1, S_WAIT = 2, S_RDY = 3, S_FLY = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_excl = 0;
    logic [IDW-1:0] req_id = '0;
    logic [AW-1:0]  req_addr = '0;
    logic req_stall;
    logic [NC-1:0] snp_valid = '0, snp_shared = '0, snp_dirty = '0;
    logic wb_valid = 0;
    logic [AW-1:0] wb_addr = '0;
    logic [DW-1:0] wb_data = '0;
    logic fill_valid, fill_shared;
    logic [IDW-1:0] fill_id;
    logic [AW-1:0]  fill_addr;
    logic [DW-1:0]  fill_data;

    always #5 clk = ~clk;

    snoop_mem_ctrl #(.N_CACHE(NC), .N_ENT(NE), .ID_W(IDW), .ADDR_W(AW),
                     .DATA_W(DW), .MEM_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_excl(req_excl),
        .req_id(req_id), .req_addr(req_addr), .req_stall(req_stall),
        .snp_valid(snp_valid), .snp_shared(snp_shared), .snp_dirty(snp_dirty),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .fill_valid(fill_valid), .fill_id(fill_id), .fill_addr(fill_addr),
        .fill_data(fill_data), .fill_shared(fill_shared)
    );

    // ---------------- behavioural reference ----------------
    typedef struct { int slot; int age; } pend_t;
    pend_t pq[$];
    int m_st [NE];
    int m_addr [NE];
    int m_id [NE];
    bit m_excl [NE];
    bit m_shr [NE];
    logic [DW-1:0] m_mem [LINES];
    bit m_coll;
    int m_cs;
    logic [NC-1:0] accv, accs, accd;
    int n_acc = 0, fills_seen = 0;

    int vec = 0, fails = 0, cyc = 0;
    bit running = 0, finished = 0;
    string cur_req = "R1";

    function automatic bit m_stall_f();
        bit anyfree = 0;
        for (int i = 0; i < NE; i++) if (m_st[i] == S_FREE) anyfree = 1;
        return m_coll || !anyfree;
    endfunction

    function automatic bit e_valid_f();
        return (pq.size() > 0) && (pq[0].age == LAT);
    endfunction

    always @(posedge clk) begin
        int snap [NE];
        int iss, fs;
        bit stall_pre;
        cyc <= cyc + 1;
        if (rst) begin
            pq.delete();
            for (int i = 0; i < NE; i++) begin
                m_st[i] = S_FREE; m_addr[i] = 0; m_id[i] = 0; m_excl[i] = 0; m_shr[i] = 0;
            end
            for (int a = 0; a < LINES; a++) m_mem[a] = DW'(a * 37 + 11);
            m_coll = 0; m_cs = 0; accv = '0; accs = '0; accd = '0;
        end else begin
            for (int i = 0; i < NE; i++) snap[i] = m_st[i];
            stall_pre = m_stall_f();
            if (e_valid_f()) begin
                m_st[pq[0].slot] = S_FREE;
                void'(pq.pop_front());
            end
            if (wb_valid) m_mem[wb_addr] = wb_data;
            iss = -1;
            for (int i = 0; i < NE; i++) if (snap[i] == S_RDY && iss < 0) iss = i;
            for (int k = 0; k < pq.size(); k++) pq[k].age = pq[k].age + 1;
            if (iss >= 0) begin
                pend_t p;
                p.slot = iss; p.age = 1;
                m_st[iss] = S_FLY;
                pq.push_back(p);
            end
            for (int i = 0; i < NE; i++)
                if (snap[i] == S_WAIT && wb_valid && m_addr[i] == int'(wb_addr)) m_st[i] = S_RDY;
            if (m_coll) begin
                accv = accv | snp_valid;
                accs = accs | (snp_valid & snp_shared);
                accd = accd | (snp_valid & snp_dirty);
                if (&accv) begin
                    m_shr[m_cs] = (accs != 0) || (accd != 0);
                    m_st[m_cs] = (accd != 0 && !(wb_valid && int'(wb_addr) == m_addr[m_cs])) ? S_WAIT : S_RDY;
                    m_coll = 0;
                end
            end
            if (req_valid && !stall_pre) begin
                fs = -1;
                for (int i = 0; i < NE; i++) if (snap[i] == S_FREE && fs < 0) fs = i;
                m_st[fs] = S_SNP; m_addr[fs] = int'(req_addr); m_id[fs] = int'(req_id);
                m_excl[fs] = req_excl; m_shr[fs] = 0;
                m_coll = 1; m_cs = fs; accv = '0; accs = '0; accd = '0;
                n_acc++;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (running && !rst) begin
            bit ev;
            int s;
            ev = e_valid_f();
            vec++;
            if (req_stall !== m_stall_f()) begin
                fails++;
                $display("FAIL %s stall: actual %b expected %b (cycle %0d)", cur_req, req_stall, m_stall_f(), cyc);
            end
            if (fill_valid !== ev) begin
                fails++;
                $display("FAIL %s fill_valid: actual %b expected %b (cycle %0d)", cur_req, fill_valid, ev, cyc);
            end else if (ev) begin
                s = pq[0].slot;
                fills_seen++;
                if (fill_id !== IDW'(m_id[s]) || fill_addr !== AW'(m_addr[s]) ||
                    fill_data !== m_mem[m_addr[s]] || fill_shared !== (m_shr[s] && !m_excl[s])) begin
                    fails++;
                    $display("FAIL %s fill: actual id=%0d addr=%0d data=%h sh=%b expected id=%0d addr=%0d data=%h sh=%b",
                             cur_req, fill_id, fill_addr, fill_data, fill_shared,
                             m_id[s], m_addr[s], m_mem[m_addr[s]], m_shr[s] && !m_excl[s]);
                end
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wb_cycle(input int a, input logic [DW-1:0] d);
        wb_valid = 1; wb_addr = AW'(a); wb_data = d;
        @(negedge clk);
        wb_valid = 0;
    endtask

    task automatic do_req(input bit excl, input int id, input int a,
                          input logic [NC-1:0] shm, input logic [NC-1:0] dtm,
                          input bit stagger, input bit noise,
                          input bit wb_end, input logic [DW-1:0] wbd);
        while (m_stall_f()) @(negedge clk);
        req_valid = 1; req_excl = excl; req_id = IDW'(id); req_addr = AW'(a);
        @(negedge clk);
        req_valid = 0;
        if (!stagger) begin
            snp_valid = '1; snp_shared = shm; snp_dirty = dtm;
            if (wb_end) begin wb_valid = 1; wb_addr = AW'(a); wb_data = wbd; end
            @(negedge clk);
        end else begin
            for (int k = 0; k < NC; k++) begin
                logic [NC-1:0] v;
                v = NC'(1) << k;
                snp_valid  = v;
                snp_shared = noise ? (~v | (shm & v)) : (shm & v);
                snp_dirty  = noise ? (~v | (dtm & v)) : (dtm & v);
                if (wb_end && k == NC - 1) begin wb_valid = 1; wb_addr = AW'(a); wb_data = wbd; end
                @(negedge clk);
            end
        end
        snp_valid = '0; snp_shared = '0; snp_dirty = '0; wb_valid = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        fails++;
        $display("FAIL watchdog: actual cycle %0d expected completion before 150000", cyc);
        finish_run();
    end

    initial begin
        rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
        running = 1;
        @(negedge clk);
        // R1: reset state
        vec++;
        if (req_stall !== 1'b0 || fill_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual stall=%b fill=%b expected 0 0", req_stall, fill_valid);
        end
        cur_req = "R1";  // initial memory content observed through a clean fill
        do_req(0, 1, 3, '0, '0, 0, 0, 0, '0); idle(10);

        cur_req = "R4";
        do_req(0, 2, 0, '0, '0, 0, 0, 0, '0); idle(10);

        cur_req = "R7";
        do_req(0, 2, 5, 4'b0010, '0, 0, 0, 0, '0); idle(10);
        do_req(1, 3, 6, 4'b0110, '0, 0, 0, 0, '0); idle(10);

        cur_req = "R3";
        do_req(0, 0, 8, '0, '0, 1, 1, 0, '0); idle(10);
        do_req(0, 1, 8, 4'b0100, '0, 1, 1, 0, '0); idle(10);

        cur_req = "R5";
        do_req(0, 0, 7, '0, 4'b0100, 1, 0, 0, '0); idle(12);
        wb_cycle(7, 16'hBEEF); idle(10);

        cur_req = "R11";
        do_req(1, 1, 9, '0, 4'b0001, 0, 0, 0, '0);
        do_req(0, 2, 2, '0, '0, 0, 0, 0, '0);
        idle(10);
        cur_req = "R8";
        wb_cycle(9, 16'h1234); idle(10);

        cur_req = "R6";
        do_req(0, 3, 4, '0, '0, 0, 0, 0, '0);
        while (!e_valid_f()) @(negedge clk);
        wb_cycle(4, 16'hCAFE); idle(2);
        do_req(0, 3, 4, '0, '0, 0, 0, 0, '0); idle(10);

        cur_req = "R10";
        do_req(0, 1, 10, '0, 4'b1000, 0, 0, 0, '0);
        do_req(0, 2, 10, '0, 4'b1000, 0, 0, 0, '0);
        idle(4);
        wb_cycle(10, 16'h0A0A); idle(12);

        cur_req = "R5";
        do_req(1, 0, 11, '0, 4'b0010, 1, 0, 1, 16'h7777); idle(12);

        cur_req = "R9";
        for (int j = 0; j < NE; j++) do_req(0, j, 12 + j, '0, 4'b0001, 0, 0, 0, '0);
        idle(2);
        req_valid = 1; req_excl = 0; req_id = 2'd3; req_addr = 4'd1;
        @(negedge clk);
        req_valid = 0;
        idle(3);
        for (int j = NE - 1; j >= 0; j--) wb_cycle(12 + j, DW'(16'h5000 + j));
        idle(12);

        cur_req = "R8";
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 3) == 0 || m_stall_f())
                wb_cycle(int'($urandom_range(0, 3)), DW'($urandom));
            else
                do_req(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                       int'($urandom_range(0, 3)), NC'($urandom),
                       ($urandom_range(0, 2) == 0) ? NC'($urandom) : '0,
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, '0);
        end
        for (int a = 0; a < LINES; a++) wb_cycle(a, DW'(a * 3));
        idle(20);

        cur_req = "R9";
        vec++;
        if (fills_seen != n_acc) begin
            fails++;
            $display("FAIL R9 fill count: actual %0d expected %0d", fills_seen, n_acc);
        end
        running = 0;
        finish_run();
    end
endmodule